// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit, byte-addressed, big-endian data memory and the register file. Each cycle it may accept one memory instruction, given by its primary opcode and function code together with the byte address already computed upstream and the store source operand. It decodes the access kind (load or store) and width (byte, halfword, word). It then drives the memory with a word-aligned address, a read strobe or a four-bit byte-enable mask, and store data copied into every lane the access could touch.

Load data comes back from a synchronous memory one cycle after the read strobe. The block picks the addressed byte or halfword out of the returned word, sign-extends it to 32 bits and presents it as a load result. Halfwords at odd addresses and words at addresses that are not multiples of four are flagged as misaligned and never reach the memory.

Top module: `ls_lane_aligner`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, mem_re, mem_we, mem_misalign and ld_valid are all 0, whatever the request inputs carry.
- R2: Only these encodings start an access. Opcode 000000 with function 100000 is a word load, 101000 a word store, 100001 a halfword load and 101001 a halfword store. Opcode 000100 is a word load, 001000 a word store, 000101 a halfword load, 001001 a halfword store, 000110 a byte load and 001010 a byte store. Any other encoding, or req_valid low, gives mem_re=0, mem_we=0 and mem_misalign=0 on the next cycle.
- R3: One cycle after an accepted aligned access, mem_addr equals req_addr with its two low bits cleared.
- R4: One cycle after an aligned store, mem_we holds the lane mask, where bit 3 covers data bits 31:24 and bit 0 covers bits 7:0. A word store gives 1111. A halfword store gives 1100 at offset 0 and 0011 at offset 2. A byte store at offset k (req_addr[1:0]) gives 1000 shifted right by k.
- R5: One cycle after an aligned store, mem_wdata is req_wdata for a word, {2{req_wdata[15:0]}} for a halfword and {4{req_wdata[7:0]}} for a byte.
- R6: One cycle after an aligned load, mem_re is 1 and mem_we is 0000. A read and a write never occur in the same cycle.
- R7: Three cycles after a byte load, ld_valid is 1 and ld_data is the sign-extended byte lane of the word on mem_rdata during the second cycle after the request. Offset 0 selects bits 31:24 and offset 3 selects bits 7:0.
- R8: For a halfword load, ld_data is bits 31:16 of that returned word at offset 0, or bits 15:0 at offset 2, sign-extended to 32 bits.
- R9: For a word load, ld_data is the returned word unchanged.
- R10: A halfword with req_addr[0]=1, or a word with req_addr[1:0]≠00, raises mem_misalign for exactly the next cycle with mem_re=0 and mem_we=0000, and produces no load result. Byte accesses are never misaligned.
- R11: A new request may be given every cycle. ld_valid is 1 in exactly those cycles that fall three cycles after an aligned load, and results come out in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A memory instruction is offered this cycle |
| req_opcode | input | 6 | Primary opcode of the instruction |
| req_func | input | 6 | Function code (used with opcode 000000) |
| req_addr | input | ADDR_W | Byte address from the address adder |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_misalign | output | 1 | The access one cycle earlier was misaligned |
| mem_rdata | input | 32 | Word returned by memory the cycle after mem_re |
| ld_valid | output | 1 | Load result is valid |
| ld_data | output | 32 | Sign-extended load result |

## Verification
The memory-side outputs (mem_re, mem_we, mem_addr, mem_wdata, mem_misalign) are due one cycle after the request. The returned word must be present during the second cycle, and ld_valid with ld_data is due in the third. The bench drives one request on each falling edge and records, for the next falling edge, the memory-side values the request should cause. It also queues each expected load result tagged with the cycle number three cycles ahead. On every falling edge it compares all outputs with these expectations. A cycle with no queued entry must show ld_valid low, which catches results that are early, late, missing or extra.

// File: rtl/lsa_pkg.sv
// Shared definitions for the load/store lane aligner.
// Assumes a 32-bit, four-lane, big-endian data word.
package lsa_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_STORE = 2'd2
    } acc_cmd_e;

    typedef struct packed {
        acc_cmd_e  cmd;
        acc_size_e size;
    } acc_kind_t;

    // Instruction encodings
    localparam logic [5:0] OPC_REGIDX   = 6'b000000;
    localparam logic [5:0] FN_LD_WORD   = 6'b100000;
    localparam logic [5:0] FN_ST_WORD   = 6'b101000;
    localparam logic [5:0] FN_LD_HALF   = 6'b100001;
    localparam logic [5:0] FN_ST_HALF   = 6'b101001;
    localparam logic [5:0] OPC_LD_WORD  = 6'b000100;
    localparam logic [5:0] OPC_ST_WORD  = 6'b001000;
    localparam logic [5:0] OPC_LD_HALF  = 6'b000101;
    localparam logic [5:0] OPC_ST_HALF  = 6'b001001;
    localparam logic [5:0] OPC_LD_BYTE  = 6'b000110;
    localparam logic [5:0] OPC_ST_BYTE  = 6'b001010;
endpackage

// File: rtl/lsa_decode.sv
// Instruction decoder: maps opcode/function code to access kind and width.
// Assumes function code matters only for the register-indexed opcode.
module lsa_decode
    import lsa_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] func,
    output acc_kind_t  kind
);
    // Purpose: classify the instruction; unknown encodings yield CMD_NONE.
    always_comb begin
        kind.cmd  = CMD_NONE;
        kind.size = SZ_WORD;
        case (opcode)
            OPC_REGIDX: begin
                case (func)
                    FN_LD_WORD: begin kind.cmd = CMD_LOAD;  kind.size = SZ_WORD; end
                    FN_ST_WORD: begin kind.cmd = CMD_STORE; kind.size = SZ_WORD; end
                    FN_LD_HALF: begin kind.cmd = CMD_LOAD;  kind.size = SZ_HALF; end
                    FN_ST_HALF: begin kind.cmd = CMD_STORE; kind.size = SZ_HALF; end
                    default:    kind.cmd = CMD_NONE;
                endcase
            end
            OPC_LD_WORD: begin kind.cmd = CMD_LOAD;  kind.size = SZ_WORD; end
            OPC_ST_WORD: begin kind.cmd = CMD_STORE; kind.size = SZ_WORD; end
            OPC_LD_HALF: begin kind.cmd = CMD_LOAD;  kind.size = SZ_HALF; end
            OPC_ST_HALF: begin kind.cmd = CMD_STORE; kind.size = SZ_HALF; end
            OPC_LD_BYTE: begin kind.cmd = CMD_LOAD;  kind.size = SZ_BYTE; end
            OPC_ST_BYTE: begin kind.cmd = CMD_STORE; kind.size = SZ_BYTE; end
            default:     kind.cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/lsa_store_lanes.sv
// Store lane generator: byte enables, replicated store data, misalignment.
// Assumes big-endian lanes: lane 0 (offset 0) is the most significant byte.
module lsa_store_lanes
    import lsa_pkg::*;
(
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    input  logic [WORD_W-1:0]  src,
    output logic [LANES-1:0]   lane_en,
    output logic [WORD_W-1:0]  lane_data,
    output logic               misaligned
);
    // Purpose: a halfword needs an even offset, a word needs offset zero.
    always_comb begin
        case (size)
            SZ_HALF: misaligned = off[0];
            SZ_WORD: misaligned = (off != '0);
            default: misaligned = 1'b0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int              BIT_HI = WORD_W - 1 - LANE_W * i;
        localparam logic [OFF_W-1:0] IDX   = OFF_W'(i);
        localparam int              HALF_HI = LANE_W * (2 - (i % 2)) - 1;
        logic              hit;
        logic [LANE_W-1:0] lane_byte;

        // Purpose: decide whether this lane belongs to the addressed field.
        always_comb begin
            case (size)
                SZ_BYTE: hit = (off == IDX);
                SZ_HALF: hit = (off[OFF_W-1:1] == IDX[OFF_W-1:1]);
                default: hit = 1'b1;
            endcase
        end

        // Purpose: pick the source byte that lands in this lane.
        always_comb begin
            case (size)
                SZ_BYTE: lane_byte = src[LANE_W-1:0];
                SZ_HALF: lane_byte = src[HALF_HI -: LANE_W];
                default: lane_byte = src[BIT_HI -: LANE_W];
            endcase
        end

        assign lane_en[LANES-1-i]           = hit;
        assign lane_data[BIT_HI -: LANE_W]  = lane_byte;
    end
endmodule

// File: rtl/lsa_load_extract.sv
// Load extractor: selects the addressed byte or halfword of a returned word
// and sign-extends it. Assumes big-endian lanes and an aligned access.
module lsa_load_extract
    import lsa_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  logic [OFF_W-1:0]   off,
    input  acc_size_e          size,
    output logic [WORD_W-1:0]  result
);
    logic [LANE_W-1:0]   byte_sel;
    logic [2*LANE_W-1:0] half_sel;

    // Purpose: lane selection by offset, most significant lane at offset 0.
    always_comb begin
        byte_sel = word[LANE_W * (LANES - 1 - int'(off)) +: LANE_W];
        half_sel = off[OFF_W-1] ? word[2*LANE_W-1:0] : word[WORD_W-1 -: 2*LANE_W];
    end

    // Purpose: sign-extend the selected field to the full width.
    always_comb begin
        case (size)
            SZ_BYTE: result = {{(WORD_W-LANE_W){byte_sel[LANE_W-1]}}, byte_sel};
            SZ_HALF: result = {{(WORD_W-2*LANE_W){half_sel[2*LANE_W-1]}}, half_sel};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/ls_lane_aligner.sv
// Load/store lane aligner top. Stage 0 registers the memory request,
// stage 1 tracks the outstanding read, stage 2 registers the load result.
// Assumes a synchronous memory that returns data the cycle after mem_re.
module ls_lane_aligner
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [5:0]        req_opcode,
    input  logic [5:0]        req_func,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic [LANES-1:0]  mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_misalign,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [WORD_W-1:0] ld_data
);
    acc_kind_t           kind;
    logic [LANES-1:0]    lane_en;
    logic [WORD_W-1:0]   lane_data;
    logic                misaligned;
    logic                access;
    logic [OFF_W-1:0]    s0_off;
    acc_size_e           s0_size;
    logic                pend_valid;
    logic [OFF_W-1:0]    pend_off;
    acc_size_e           pend_size;
    logic [WORD_W-1:0]   extracted;

    lsa_decode u_decode (
        .opcode (req_opcode),
        .func   (req_func),
        .kind   (kind)
    );

    lsa_store_lanes u_store (
        .size       (kind.size),
        .off        (req_addr[OFF_W-1:0]),
        .src        (req_wdata),
        .lane_en    (lane_en),
        .lane_data  (lane_data),
        .misaligned (misaligned)
    );

    lsa_load_extract u_extract (
        .word   (mem_rdata),
        .off    (pend_off),
        .size   (pend_size),
        .result (extracted)
    );

    assign access = req_valid && (kind.cmd != CMD_NONE);

    // Purpose: stage 0, register the memory-side request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr     <= '0;
            mem_re       <= 1'b0;
            mem_we       <= '0;
            mem_wdata    <= '0;
            mem_misalign <= 1'b0;
            s0_off       <= '0;
            s0_size      <= SZ_WORD;
        end else begin
            mem_misalign <= access && misaligned;
            mem_re       <= access && !misaligned && (kind.cmd == CMD_LOAD);
            mem_we       <= (access && !misaligned && (kind.cmd == CMD_STORE)) ? lane_en : '0;
            if (access) begin
                mem_addr <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                s0_off   <= req_addr[OFF_W-1:0];
                s0_size  <= kind.size;
            end
            if (access && kind.cmd == CMD_STORE) begin
                mem_wdata <= lane_data;
            end
        end
    end

    // Purpose: stage 1, remember offset and width of the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_off   <= '0;
            pend_size  <= SZ_WORD;
        end else begin
            pend_valid <= mem_re;
            pend_off   <= s0_off;
            pend_size  <= s0_size;
        end
    end

    // Purpose: stage 2, register the extracted, sign-extended load result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= pend_valid;
            if (pend_valid) begin
                ld_data <= extracted;
            end
        end
    end

    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_misalign |-> (mem_we == '0 && !mem_re)); // R10
    AST_NO_READ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && (mem_we != '0))); // R6
    AST_WE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_we) != 3)); // R4
    AST_ACCESS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || (mem_we != '0) || mem_misalign) |-> $past(req_valid)); // R2
    AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_re, 2)); // R11
endmodule

// File: tb/ls_lane_aligner_tb_top.sv
module ls_lane_aligner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [5:0]  req_opcode;
    logic [5:0]  req_func;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [31:0] mem_addr;
    logic        mem_re;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        mem_misalign;
    logic [31:0] mem_rdata;
    logic        ld_valid;
    logic [31:0] ld_data;

    always #4 clk = ~clk;

    ls_lane_aligner #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_func(req_func), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_misalign(mem_misalign), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    typedef struct {
        int          due;
        logic [31:0] val;
        string       tag;
    } ld_exp_t;

    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          done = 0;
    ld_exp_t     ldq[$];
    logic        e_re, e_mis, e_store;
    logic [3:0]  e_we;
    logic [31:0] e_addr, e_wd;
    logic [31:0] rd_pipe;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [29:0] idx);
        return {idx[13:0], ~idx[17:0]} ^ 32'hA5C3_96E1;
    endfunction

    // cmd: 0 none, 1 load, 2 store; sz in bytes
    function automatic void decode_ref(input logic [5:0] op, input logic [5:0] fn,
                                       output int cmd, output int sz);
        cmd = 0; sz = 4;
        case (op)
            6'b000000: case (fn)
                6'b100000: begin cmd = 1; sz = 4; end
                6'b101000: begin cmd = 2; sz = 4; end
                6'b100001: begin cmd = 1; sz = 2; end
                6'b101001: begin cmd = 2; sz = 2; end
                default:   cmd = 0;
            endcase
            6'b000100: begin cmd = 1; sz = 4; end
            6'b001000: begin cmd = 2; sz = 4; end
            6'b000101: begin cmd = 1; sz = 2; end
            6'b001001: begin cmd = 2; sz = 2; end
            6'b000110: begin cmd = 1; sz = 1; end
            6'b001010: begin cmd = 2; sz = 1; end
            default:   cmd = 0;
        endcase
    endfunction

    function automatic logic [7:0] byte_at(input logic [31:0] w, input int k);
        return 8'((w >> (8 * (3 - k))) & 32'hFF);
    endfunction

    function automatic logic [31:0] load_ref(input logic [31:0] w, input int sz, input int off);
        logic [15:0] h;
        if (sz == 1) return 32'($signed(byte_at(w, off)));
        if (sz == 2) begin
            h = {byte_at(w, off & 2), byte_at(w, (off & 2) + 1)};
            return 32'($signed(h));
        end
        return w;
    endfunction

    task automatic check_outputs();
        chk(e_mis ? "R10 misalign" : "R10 misalign idle", {31'd0, mem_misalign}, {31'd0, e_mis});
        chk(e_re ? "R6 read strobe" : "R2 read strobe", {31'd0, mem_re}, {31'd0, e_re});
        chk(e_store ? "R4 byte enables" : "R2 byte enables", {28'd0, mem_we}, {28'd0, e_we});
        if (e_re || e_store) chk("R3 word address", mem_addr, e_addr);
        if (e_store) chk("R5 store data", mem_wdata, e_wd);
        if (ldq.size() > 0 && ldq[0].due == cyc) begin
            chk("R11 load valid", {31'd0, ld_valid}, 32'd1);
            chk(ldq[0].tag, ld_data, ldq[0].val);
            void'(ldq.pop_front());
        end else begin
            chk("R11 no load result", {31'd0, ld_valid}, 32'd0);
        end
    endtask

    task automatic step(input logic rv, input logic [5:0] op, input logic [5:0] fn,
                        input logic [31:0] a, input logic [31:0] d);
        int cmd, sz, off;
        logic acc;
        ld_exp_t e;
        @(negedge clk);
        cyc++;
        check_outputs();
        mem_rdata = rd_pipe;
        if (mem_re) rd_pipe = mem_word(mem_addr[31:2]);
        req_valid = rv; req_opcode = op; req_func = fn; req_addr = a; req_wdata = d;
        decode_ref(op, fn, cmd, sz);
        off = int'(a[1:0]);
        acc = rv && (cmd != 0);
        e_mis = acc && ((sz == 2 && a[0]) || (sz == 4 && a[1:0] != 2'b00));
        e_re = acc && cmd == 1 && !e_mis;
        e_store = acc && cmd == 2 && !e_mis;
        e_we = 4'h0;
        if (e_store) e_we = (sz == 4) ? 4'hF : (sz == 2) ? (a[1] ? 4'h3 : 4'hC) : (4'b1000 >> off);
        e_addr = {a[31:2], 2'b00};
        e_wd = (sz == 1) ? {4{d[7:0]}} : (sz == 2) ? {2{d[15:0]}} : d;
        if (e_re) begin
            e.due = cyc + 3;
            e.val = load_ref(mem_word(a[31:2]), sz, off);
            e.tag = (sz == 1) ? "R7 byte load" : (sz == 2) ? "R8 half load" : "R9 word load";
            ldq.push_back(e);
        end
    endtask

    task automatic pick(input int k, output logic [5:0] op, output logic [5:0] fn);
        fn = 6'b000000;
        case (k)
            0:  begin op = 6'b000000; fn = 6'b100000; end
            1:  begin op = 6'b000000; fn = 6'b101000; end
            2:  begin op = 6'b000000; fn = 6'b100001; end
            3:  begin op = 6'b000000; fn = 6'b101001; end
            4:  op = 6'b000100;
            5:  op = 6'b001000;
            6:  op = 6'b000101;
            7:  op = 6'b001001;
            8:  op = 6'b000110;
            9:  op = 6'b001010;
            10: begin op = 6'b000000; fn = 6'b000100; end
            default: op = 6'b111110;
        endcase
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; req_opcode = 6'b001000; req_func = 6'd0;
        req_addr = 32'h40; req_wdata = 32'hDEADBEEF; mem_rdata = 32'd0; rd_pipe = 32'd0;
        e_re = 0; e_mis = 0; e_store = 0; e_we = 4'h0; e_addr = 0; e_wd = 0;
        repeat (3) @(negedge clk);
        // R1: reset holds everything quiet even with a store offered
        chk("R1 reset read", {31'd0, mem_re}, 32'd0);
        chk("R1 reset enables", {28'd0, mem_we}, 32'd0);
        chk("R1 reset misalign", {31'd0, mem_misalign}, 32'd0);
        chk("R1 reset load valid", {31'd0, ld_valid}, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        // word, halfword loads/stores, register-indexed forms
        step(1, 6'b000000, 6'b100000, 32'h0000_0100, 32'h0);
        step(1, 6'b000000, 6'b101000, 32'h0000_0104, 32'h1122_3344);
        step(1, 6'b000000, 6'b100001, 32'h0000_0108, 32'h0);
        step(1, 6'b000000, 6'b100001, 32'h0000_010A, 32'h0);
        step(1, 6'b000000, 6'b101001, 32'h0000_010E, 32'hAAAA_8765);
        step(1, 6'b000000, 6'b101001, 32'h0000_010C, 32'h0000_1234);
        // byte loads and stores at every offset (R7, R4, R5)
        for (int k = 0; k < 4; k++) step(1, 6'b000110, 6'd0, 32'h0000_0200 + k, 32'h0);
        for (int k = 0; k < 4; k++) step(1, 6'b001010, 6'd0, 32'h0000_0210 + k, 32'h0000_00A0 + k);
        // immediate-offset word/half forms
        step(1, 6'b000100, 6'd0, 32'hFFFF_FFF0, 32'h0);
        step(1, 6'b001000, 6'd0, 32'h8000_0004, 32'hCAFE_F00D);
        step(1, 6'b000101, 6'd0, 32'h0000_0302, 32'h0);
        step(1, 6'b001001, 6'd0, 32'h0000_0300, 32'h0000_BEEF);
        // R10 misaligned cases
        step(1, 6'b000101, 6'd0, 32'h0000_0401, 32'h0);
        step(1, 6'b000000, 6'b100001, 32'h0000_0403, 32'h0);
        for (int k = 1; k < 4; k++) step(1, 6'b000100, 6'd0, 32'h0000_0410 + k, 32'h0);
        step(1, 6'b001001, 6'd0, 32'h0000_0421, 32'h5555_5555);
        step(1, 6'b000000, 6'b101000, 32'h0000_0422, 32'h5555_5555);
        // R2 non-access encodings and idle valid
        step(1, 6'b000000, 6'b000100, 32'h0000_0500, 32'h1);
        step(1, 6'b111111, 6'd0, 32'h0000_0504, 32'h1);
        step(0, 6'b001000, 6'd0, 32'h0000_0508, 32'h1);
        step(0, 6'b000100, 6'd0, 32'h0000_050C, 32'h1);
        // R11 back-to-back mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [5:0] op, fn;
            pick(int'($urandom_range(0, 11)), op, fn);
            step(($urandom_range(0, 7) != 0), op, fn, {20'h0, 12'($urandom)}, $urandom);
        end
        for (int n = 0; n < 5; n++) step(0, 6'd0, 6'd0, 32'h0, 32'h0);
        chk("R11 all load results seen", ldq.size(), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule